// File: doc/BRIEF.md
# Single-Channel Minor/Major Loop DMA Engine

This block moves data between two regions of a word-addressed memory without processor help. Software writes a descriptor through a load strobe. The descriptor holds the source address, the destination address, the byte count per minor loop, the iteration count, the interrupt enables and an auto-disable flag. Each accepted hardware request, or a software start, runs one minor loop. A minor loop is a sequence of read/write word beats on a simple master port. When the loop ends, the advanced addresses and the decremented iteration counter are written back into the descriptor.

Several minor loops make up a major loop. The current iteration counter starts at the beginning count and counts down to zero. When it reaches zero the engine:
- sets a sticky completion flag;
- reloads the counter;
- can pulse a completion interrupt;
- can drop its own request enable.

A half-way interrupt can also be enabled.

The memory port has fixed timing. Read data returns on `mem_rdata` in the cycle after `mem_re`, and the engine writes that word in the following cycle. A descriptor load is accepted only while `active` is low. The beginning count must be nonzero.

Top module: `dma_loop_engine`

## Requirements
- R1: A minor loop issues NBYTES/4 read/write beat pairs. Each read cycle (`mem_re`=1, address = working source) is followed by one write cycle (`mem_we`=1, address = working destination, data = the word just read). Both addresses step by 4 after each pair.
- R2: When a minor loop ends, `cur_saddr` and `cur_daddr` hold their start values plus NBYTES, and `cur_citer` is one less, unless R3 applies.
- R3: When a minor loop leaves the iteration count at zero, `done` is set and `cur_citer` is reloaded with the beginning count. The addresses keep their advanced values.
- R4: A `sw_start` pulse sets `start_bit`. The bit clears in the cycle `active` rises, and that start runs one minor loop even when `req_en` is 0.
- R5: `active` is high only while a minor loop is executing. `mem_re` and `mem_we` are never both high, and neither is high while idle.
- R6: `done` stays set until a `done_clr` pulse clears it.
- R7: A `hw_req` pulse is ignored while `req_en` is 0. When the auto-disable flag is loaded as 1, `req_en` drops to 0 at major loop completion.
- R8: With the half interrupt enabled, `irq_half` pulses for one cycle after the minor loop that leaves `cur_citer` equal to BITER/2 (integer division). It never pulses when BITER is 1.
- R9: With the major interrupt enabled, `irq_major` pulses for one cycle at major loop completion, with `done` already high.
- R10: If NBYTES is 0 or not a multiple of 4 when a service begins, `cfg_err` is set, no memory beat is issued, and the pending start or request is consumed. A descriptor load clears `cfg_err`.
- R11: A `hw_req` that arrives while `active` is high is held, and a second minor loop runs after the current one ends.
- R12: After reset, `active`, `done`, `req_en`, `cfg_err`, `start_bit`, the interrupt pulses and the memory strobes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Descriptor load strobe (ignored while active) |
| ld_saddr | input | AW | Source address to load |
| ld_daddr | input | AW | Destination address to load |
| ld_nbytes | input | NBW | Bytes per minor loop |
| ld_biter | input | IW | Beginning iteration count (nonzero) |
| ld_half_en | input | 1 | Half-complete interrupt enable |
| ld_major_en | input | 1 | Completion interrupt enable |
| ld_auto_dis | input | 1 | Drop request enable at completion |
| ld_req_en | input | 1 | Hardware request enable value |
| sw_start | input | 1 | Software start pulse |
| done_clr | input | 1 | Clear completion flag |
| hw_req | input | 1 | Hardware service request pulse |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| cur_saddr | output | AW | Descriptor source address |
| cur_daddr | output | AW | Descriptor destination address |
| cur_citer | output | IW | Current iteration count |
| start_bit | output | 1 | Pending software start |
| active | output | 1 | Minor loop executing |
| done | output | 1 | Major loop completed (sticky) |
| req_en | output | 1 | Hardware request enable |
| cfg_err | output | 1 | Byte-count configuration error |
| irq_half | output | 1 | Half-complete interrupt pulse |
| irq_major | output | 1 | Completion interrupt pulse |

## Verification
Some properties are checked on every cycle: the read-then-write beat pairing, that `active` ends only after a write beat, and that `start_bit` is clear once the channel begins. Others are also checked each cycle: both interrupts coincide with the end of a minor loop, the completion pulse implies `done`, `done` is sticky, and a configuration error never starts a beat. Only the bench scenarios can show the rest. These are the copied data values, the address and count write-back across several NBYTES/BITER combinations, the exact half-point choice, the held second request, request gating and auto-disable, and the error cases for byte counts 6 and 0.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NB_W   = 16;
    localparam int unsigned ITER_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } beat_state_e;

    typedef struct packed {
        logic half_irq_en;
        logic major_irq_en;
        logic auto_disable;
    } chan_ctrl_t;

endpackage

// File: rtl/dma_minor_fsm.sv
module dma_minor_fsm
    import dma_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned NBW = NB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [AW-1:0] start_src,
    input  logic [AW-1:0] start_dst,
    input  logic [NBW-1:0] start_bytes,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          fin,
    output logic [AW-1:0] fin_src,
    output logic [AW-1:0] fin_dst
);
    localparam int unsigned WORD_BYTES = DW / 8;
    localparam logic [NBW-1:0] STEP_NB = NBW'(WORD_BYTES);
    localparam logic [AW-1:0]  STEP_A  = AW'(WORD_BYTES);

    beat_state_e   state;
    logic [AW-1:0] src_q, dst_q;
    logic [NBW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (launch) begin
                    state  <= ST_READ;
                    src_q  <= start_src;
                    dst_q  <= start_dst;
                    left_q <= start_bytes;
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    src_q  <= src_q + STEP_A;
                    dst_q  <= dst_q + STEP_A;
                    left_q <= left_q - STEP_NB;
                    state  <= (left_q == STEP_NB) ? ST_IDLE : ST_READ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_re    = (state == ST_READ);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? dst_q : src_q;
        mem_wdata = mem_rdata;
        busy      = (state != ST_IDLE);
        fin       = (state == ST_WRITE) && (left_q == STEP_NB);
        fin_src   = src_q + STEP_A;
        fin_dst   = dst_q + STEP_A;
    end

endmodule

// File: rtl/dma_desc_ctl.sv
module dma_desc_ctl
    import dma_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned NBW = NB_W,
    parameter int unsigned IW  = ITER_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic [AW-1:0]  ld_saddr,
    input  logic [AW-1:0]  ld_daddr,
    input  logic [NBW-1:0] ld_nbytes,
    input  logic [IW-1:0]  ld_biter,
    input  chan_ctrl_t     ld_ctrl,
    input  logic           ld_req_en,
    input  logic           sw_start,
    input  logic           done_clr,
    input  logic           hw_req,
    input  logic           busy,
    input  logic           fin,
    input  logic [AW-1:0]  fin_src,
    input  logic [AW-1:0]  fin_dst,
    output logic           launch,
    output logic [AW-1:0]  saddr,
    output logic [AW-1:0]  daddr,
    output logic [NBW-1:0] nbytes,
    output logic [IW-1:0]  citer,
    output logic           start_bit,
    output logic           done,
    output logic           req_en,
    output logic           cfg_err,
    output logic           irq_half,
    output logic           irq_major
);
    localparam int unsigned LSB = $clog2(DW / 8);

    logic [IW-1:0] biter_q;
    chan_ctrl_t    ctrl_q;
    logic          pend_q;
    logic          want, nb_ok;
    logic [IW-1:0] citer_dec;

    always_comb begin
        want      = (start_bit || pend_q) && !busy;
        nb_ok     = (nbytes != '0) && (nbytes[LSB-1:0] == '0);
        launch    = want && nb_ok;
        citer_dec = citer - IW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saddr     <= '0;
            daddr     <= '0;
            nbytes    <= '0;
            citer     <= '0;
            biter_q   <= '0;
            ctrl_q    <= '0;
            pend_q    <= 1'b0;
            start_bit <= 1'b0;
            done      <= 1'b0;
            req_en    <= 1'b0;
            cfg_err   <= 1'b0;
            irq_half  <= 1'b0;
            irq_major <= 1'b0;
        end else begin
            irq_half  <= 1'b0;
            irq_major <= 1'b0;
            if (ld && !busy) begin
                saddr   <= ld_saddr;
                daddr   <= ld_daddr;
                nbytes  <= ld_nbytes;
                citer   <= ld_biter;
                biter_q <= ld_biter;
                ctrl_q  <= ld_ctrl;
                req_en  <= ld_req_en;
                cfg_err <= 1'b0;
                pend_q  <= 1'b0;
            end
            if (want) begin
                start_bit <= 1'b0;
                pend_q    <= 1'b0;
                if (!nb_ok) cfg_err <= 1'b1;
            end
            if (sw_start) start_bit <= 1'b1;
            if (hw_req && req_en) pend_q <= 1'b1;
            if (done_clr) done <= 1'b0;
            if (fin) begin
                saddr <= fin_src;
                daddr <= fin_dst;
                if (citer == IW'(1)) begin
                    citer     <= biter_q;
                    done      <= 1'b1;
                    irq_major <= ctrl_q.major_irq_en;
                    if (ctrl_q.auto_disable) req_en <= 1'b0;
                end else begin
                    citer    <= citer_dec;
                    irq_half <= ctrl_q.half_irq_en && (citer_dec == (biter_q >> 1));
                end
            end
        end
    end

endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
    import dma_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned NBW = NB_W,
    parameter int unsigned IW  = ITER_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic [AW-1:0]  ld_saddr,
    input  logic [AW-1:0]  ld_daddr,
    input  logic [NBW-1:0] ld_nbytes,
    input  logic [IW-1:0]  ld_biter,
    input  logic           ld_half_en,
    input  logic           ld_major_en,
    input  logic           ld_auto_dis,
    input  logic           ld_req_en,
    input  logic           sw_start,
    input  logic           done_clr,
    input  logic           hw_req,
    output logic           mem_re,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  cur_saddr,
    output logic [AW-1:0]  cur_daddr,
    output logic [IW-1:0]  cur_citer,
    output logic           start_bit,
    output logic           active,
    output logic           done,
    output logic           req_en,
    output logic           cfg_err,
    output logic           irq_half,
    output logic           irq_major
);
    chan_ctrl_t     ctrl_in;
    logic           launch, fin;
    logic [AW-1:0]  fin_src, fin_dst;
    logic [NBW-1:0] nbytes;

    assign ctrl_in = '{half_irq_en: ld_half_en, major_irq_en: ld_major_en,
                       auto_disable: ld_auto_dis};

    dma_desc_ctl #(.AW(AW), .DW(DW), .NBW(NBW), .IW(IW)) u_desc (
        .clk(clk), .rst(rst), .ld(ld), .ld_saddr(ld_saddr), .ld_daddr(ld_daddr),
        .ld_nbytes(ld_nbytes), .ld_biter(ld_biter), .ld_ctrl(ctrl_in),
        .ld_req_en(ld_req_en), .sw_start(sw_start), .done_clr(done_clr),
        .hw_req(hw_req), .busy(active), .fin(fin), .fin_src(fin_src),
        .fin_dst(fin_dst), .launch(launch), .saddr(cur_saddr), .daddr(cur_daddr),
        .nbytes(nbytes), .citer(cur_citer), .start_bit(start_bit), .done(done),
        .req_en(req_en), .cfg_err(cfg_err), .irq_half(irq_half),
        .irq_major(irq_major)
    );

    dma_minor_fsm #(.AW(AW), .DW(DW), .NBW(NBW)) u_fsm (
        .clk(clk), .rst(rst), .launch(launch), .start_src(cur_saddr),
        .start_dst(cur_daddr), .start_bytes(nbytes), .mem_rdata(mem_rdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(active), .fin(fin), .fin_src(fin_src),
        .fin_dst(fin_dst)
    );

endmodule

// File: rtl/dma_loop_sva.sv
module dma_loop_sva (
    input logic clk,
    input logic rst,
    input logic mem_re,
    input logic mem_we,
    input logic active,
    input logic start_bit,
    input logic done,
    input logic done_clr,
    input logic cfg_err,
    input logic irq_half,
    input logic irq_major
);
    assert_read_then_write_R1: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (mem_we && !mem_re));

    assert_end_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(mem_we));

    assert_no_dual_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    assert_start_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !start_bit);

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr) |=> done);

    assert_major_sets_done_R9: assert property (@(posedge clk) disable iff (rst)
        irq_major |-> (done && $fell(active)));

    assert_half_at_loop_end_R8: assert property (@(posedge clk) disable iff (rst)
        irq_half |-> ($fell(active) && !irq_major));

    assert_cfg_no_beat_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> (!active && !mem_re));

endmodule

bind dma_loop_engine dma_loop_sva u_sva (
    .clk(clk), .rst(rst), .mem_re(mem_re), .mem_we(mem_we), .active(active),
    .start_bit(start_bit), .done(done), .done_clr(done_clr), .cfg_err(cfg_err),
    .irq_half(irq_half), .irq_major(irq_major)
);

// File: tb/tb_dma_loop_engine.sv
module tb_dma_loop_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld = 0, ld_half_en = 0, ld_major_en = 0, ld_auto_dis = 0, ld_req_en = 0;
    logic [31:0] ld_saddr = 0, ld_daddr = 0;
    logic [15:0] ld_nbytes = 0;
    logic [7:0]  ld_biter = 0;
    logic        sw_start = 0, done_clr = 0, hw_req = 0;
    logic        mem_re, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] cur_saddr, cur_daddr;
    logic [7:0]  cur_citer;
    logic        start_bit, active, done, req_en, cfg_err, irq_half, irq_major;

    int tests = 0, fails = 0;
    int n_half = 0, n_major = 0, n_re = 0;
    logic [31:0] mem [64];

    always #4 clk = ~clk;

    dma_loop_engine dut (
        .clk(clk), .rst(rst), .ld(ld), .ld_saddr(ld_saddr), .ld_daddr(ld_daddr),
        .ld_nbytes(ld_nbytes), .ld_biter(ld_biter), .ld_half_en(ld_half_en),
        .ld_major_en(ld_major_en), .ld_auto_dis(ld_auto_dis), .ld_req_en(ld_req_en),
        .sw_start(sw_start), .done_clr(done_clr), .hw_req(hw_req),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_saddr(cur_saddr),
        .cur_daddr(cur_daddr), .cur_citer(cur_citer), .start_bit(start_bit),
        .active(active), .done(done), .req_en(req_en), .cfg_err(cfg_err),
        .irq_half(irq_half), .irq_major(irq_major)
    );

    // memory model: read data one cycle after the read strobe
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[7:2]];
            n_re = n_re + 1;
        end
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (irq_half)  n_half = n_half + 1;
        if (irq_major) n_major = n_major + 1;
    end

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] nb;
        logic [7:0]  bi;
        logic        hen;
        logic        men;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{32'h00, 32'h80, 16'd4,  8'd2, 1'b1, 1'b1},
        '{32'h10, 32'hA0, 16'd8,  8'd3, 1'b1, 1'b1},
        '{32'h30, 32'hC0, 16'd12, 8'd1, 1'b1, 1'b0},
        '{32'h40, 32'hE0, 16'd16, 8'd2, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] nb,
                        input logic [7:0] bi, input logic he, input logic me,
                        input logic ad, input logic en);
        @(negedge clk);
        ld = 1; ld_saddr = s; ld_daddr = d; ld_nbytes = nb; ld_biter = bi;
        ld_half_en = he; ld_major_en = me; ld_auto_dis = ad; ld_req_en = en;
        @(negedge clk);
        ld = 0;
    endtask

    task automatic pulse_req();
        @(negedge clk); hw_req = 1;
        @(negedge clk); hw_req = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (active) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int h0, m0, r0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R12 reset state
        chk("R12 active", active, 0);
        chk("R12 done", done, 0);
        chk("R12 req_en", req_en, 0);
        chk("R12 cfg_err", cfg_err, 0);
        chk("R12 start_bit", start_bit, 0);
        chk("R12 strobes", {30'd0, mem_re, mem_we}, 0);
        chk("R12 irqs", {30'd0, irq_half, irq_major}, 0);

        // table walk: R1 R2 R3 R6 R8 R9
        for (int v = 0; v < 4; v++) begin
            h0 = n_half; m0 = n_major;
            load(VEC[v].src, VEC[v].dst, VEC[v].nb, VEC[v].bi, VEC[v].hen, VEC[v].men, 0, 1);
            for (int k = 1; k <= VEC[v].bi; k++) begin
                pulse_req();
                settle();
                chk("R2 saddr", cur_saddr, VEC[v].src + VEC[v].nb * k);
                chk("R2 daddr", cur_daddr, VEC[v].dst + VEC[v].nb * k);
                if (k < VEC[v].bi) chk("R2 citer", cur_citer, VEC[v].bi - k);
            end
            chk("R3 citer reload", cur_citer, VEC[v].bi);
            chk("R3 done", done, 1);
            chk("R7 req_en kept", req_en, 1);
            chk("R8 half count", n_half - h0, (VEC[v].hen && VEC[v].bi > 1) ? 1 : 0);
            chk("R9 major count", n_major - m0, VEC[v].men ? 1 : 0);
            for (int w = 0; w < (VEC[v].nb * VEC[v].bi) / 4; w++)
                chk("R1 data", mem[(VEC[v].dst >> 2) + w], 32'hA000_0000 + (VEC[v].src >> 2) + w);
            repeat (3) @(negedge clk);
            chk("R6 done held", done, 1);
            clear_done();
            chk("R6 done cleared", done, 0);
        end

        // R7 gating and R4 software start
        load(32'h60, 32'h90, 16'd4, 8'd2, 0, 0, 0, 0);
        pulse_req();
        settle();
        chk("R7 ignored saddr", cur_saddr, 32'h60);
        chk("R7 ignored citer", cur_citer, 2);
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
        chk("R4 start set", start_bit, 1);
        @(negedge clk);
        chk("R4 start cleared", start_bit, 0);
        chk("R5 active", active, 1);
        settle();
        chk("R4 one loop saddr", cur_saddr, 32'h64);
        chk("R4 one loop citer", cur_citer, 1);
        chk("R5 idle after", active, 0);

        // R11 request held while active
        load(32'h00, 32'h90, 16'd8, 8'd4, 0, 0, 0, 1);
        pulse_req();
        @(negedge clk);
        chk("R11 active before 2nd req", active, 1);
        pulse_req();
        settle();
        @(negedge clk);
        while (active) @(negedge clk);
        @(negedge clk);
        chk("R11 saddr", cur_saddr, 32'h10);
        chk("R11 citer", cur_citer, 2);

        // R7 auto-disable
        load(32'h00, 32'h90, 16'd4, 8'd1, 0, 1, 1, 1);
        pulse_req();
        settle();
        chk("R7 auto-disable", req_en, 0);
        chk("R3 done", done, 1);
        chk("R3 citer", cur_citer, 1);
        pulse_req();
        settle();
        chk("R7 later req ignored", cur_saddr, 32'h04);
        clear_done();

        // R10 configuration errors
        load(32'h20, 32'h90, 16'd6, 8'd2, 0, 0, 0, 1);
        r0 = n_re;
        pulse_start();
        settle();
        chk("R10 cfg_err nb=6", cfg_err, 1);
        chk("R10 start consumed", start_bit, 0);
        chk("R10 no beats", n_re - r0, 0);
        chk("R10 saddr kept", cur_saddr, 32'h20);
        load(32'h20, 32'h90, 16'd0, 8'd2, 0, 0, 0, 1);
        chk("R10 load clears", cfg_err, 0);
        pulse_req();
        settle();
        chk("R10 cfg_err nb=0", cfg_err, 1);
        chk("R10 no beats nb=0", n_re - r0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule